// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register File

This block holds the programmable state of an interrupt router behind a two-location window on a simple 32-bit register bus. Software first writes a register number into an 8-bit select location at byte offset 0. It then reads or writes the chosen register through a data location at byte offset 16. The register space contains an identity value, a read-only capability word, an arbitration identity, and a table of 64-bit redirection entries. Each entry is visible as a low and a high 32-bit half.

Every entry's fields are driven continuously out of the block to the dispatch logic: vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. Bits that hold no field are never stored, so a write clears them. A read returns its data one cycle after the strobe and holds it until the next read. An access at any other byte offset raises a one-cycle error pulse and changes no state.

Top module: `irq_route_regs`

## Requirements
- R1: A write at byte offset 0 loads the 8-bit register select from wdata[7:0]. A read at offset 0 returns the select in bits 7:0, with the upper bits zero. Read data appears on the cycle after the read strobe and holds until the next read.
- R2: Register 0 keeps a 4-bit identity taken from wdata[27:24] on a data-window write. Reading it returns the identity in bits 27:24 and zeros elsewhere.
- R3: Register 1 is read-only. It reads as N_ENT-1 in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Writes to it change nothing.
- R4: Register 2 keeps a 4-bit arbitration identity in bits 27:24, with the same write and read behaviour as register 0.
- R5: Select value 0x10+2n addresses the low half of entry n, and 0x11+2n addresses its high half, for n from 0 to N_ENT-1.
- R6: The low half stores vector in 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13, trigger mode in 15 and mask in 16. The high half stores destination in 31:24. Every other bit is dropped on write and reads as zero.
- R7: After reset, each entry has mask 1 and all other fields 0. The identity equals ID_INIT, the arbitration identity equals ID_INIT, and the select is 0.
- R8: A select value naming no register (3 to 0x0F, or 0x10+2*N_ENT and above) reads as zero through the data window. A write through the window to such a value changes no state.
- R9: A read or write at a byte offset other than 0 or 16 makes bus_err high for exactly the following cycle. It changes no register, and a read there returns zero.
- R10: The per-entry output ports always show the stored fields of every entry. They change only on the cycle after a data-window write to that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an access at an undefined offset |
| ent_vec | output | 8*N_ENT | Vector of each entry |
| ent_dmode | output | 3*N_ENT | Delivery mode of each entry |
| ent_dstm | output | N_ENT | Destination mode of each entry |
| ent_pol | output | N_ENT | Polarity of each entry |
| ent_trig | output | N_ENT | Trigger mode of each entry |
| ent_mask | output | N_ENT | Mask of each entry |
| ent_dest | output | 8*N_ENT | Destination of each entry |

## Verification
The bench writes all ones to both halves of entries. A design that failed to scrub reserved bits would then read back a word other than 0x0001AFFF or 0xFF000000. It targets the first select value past the table and the gap between registers 2 and 0x10. A window decode off by one would alias these onto an entry or return junk. It writes the read-only capability word and uses byte offsets 4, 8 and 20. A design that wrote through them, or that stretched or dropped the error pulse, shows a changed readback or a mismatched bus_err. A sweep over every entry with distinct patterns catches a wrong index-to-entry map or a swapped low/high half.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int SEL_W      = 8;
  localparam int WORD_W     = 32;
  localparam int OFF_SEL    = 0;
  localparam int OFF_WIN    = 16;
  localparam logic [SEL_W-1:0] R_IDENT = 8'h00;
  localparam logic [SEL_W-1:0] R_CAPS  = 8'h01;
  localparam logic [SEL_W-1:0] R_ARBID = 8'h02;
  localparam logic [SEL_W-1:0] R_TABLE = 8'h10;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dstm;
    logic [2:0] dmode;
    logic [7:0] vec;
  } redir_t;

  localparam redir_t REDIR_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                   pol: 1'b0, dstm: 1'b0, dmode: 3'b000,
                                   vec: 8'h00};

  function automatic logic [WORD_W-1:0] lo_image(redir_t e);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = e.vec;
    w[10:8]  = e.dmode;
    w[11]    = e.dstm;
    w[13]    = e.pol;
    w[15]    = e.trig;
    w[16]    = e.mask;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] hi_image(redir_t e);
    return {e.dest, 24'h000000};
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic              win_wr,
  output logic              win_rd,
  output logic              bad_acc
);
  import irq_route_pkg::*;

  logic at_sel, at_win;

  always_comb begin
    at_sel  = (addr == ADDR_W'(OFF_SEL));
    at_win  = (addr == ADDR_W'(OFF_WIN));
    sel_wr  = wr & at_sel;
    sel_rd  = rd & at_sel;
    win_wr  = wr & at_win;
    win_rd  = rd & at_win;
    bad_acc = (wr | rd) & ~at_sel & ~at_win;
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_lo,
  input  logic                          wr_hi,
  input  logic [31:0]                   wdata,
  output irq_route_pkg::redir_t         ent
);
  import irq_route_pkg::*;

  redir_t ent_q, ent_d;
  logic   unused_resv;

  assign unused_resv = ^{wdata[23:17], wdata[14], wdata[12]};

  always_comb begin
    ent_d = ent_q;
    if (wr_lo) begin
      ent_d.vec   = wdata[7:0];
      ent_d.dmode = wdata[10:8];
      ent_d.dstm  = wdata[11];
      ent_d.pol   = wdata[13];
      ent_d.trig  = wdata[15];
      ent_d.mask  = wdata[16];
    end
    if (wr_hi) begin
      ent_d.dest = wdata[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= REDIR_RST;
    else if (wr_lo | wr_hi) ent_q <= ent_d;
  end

  assign ent = ent_q;
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int          N_ENT   = 24,
  parameter int          ADDR_W  = 8,
  parameter logic [3:0]  ID_INIT = 4'h3,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [8*N_ENT-1:0]   ent_vec,
  output logic [3*N_ENT-1:0]   ent_dmode,
  output logic [N_ENT-1:0]     ent_dstm,
  output logic [N_ENT-1:0]     ent_pol,
  output logic [N_ENT-1:0]     ent_trig,
  output logic [N_ENT-1:0]     ent_mask,
  output logic [8*N_ENT-1:0]   ent_dest
);
  import irq_route_pkg::*;

  localparam logic [SEL_W:0] TBL_END = (SEL_W+1)'(16 + 2*N_ENT);
  localparam logic [7:0]     TOP_IDX = 8'(N_ENT - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic sel_wr, sel_rd, win_wr, win_rd, bad_acc;
  irq_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .sel_wr(sel_wr), .sel_rd(sel_rd), .win_wr(win_wr), .win_rd(win_rd),
    .bad_acc(bad_acc)
  );

  logic [SEL_W-1:0] sel_q, sel_d;
  logic [3:0]       id_q, id_d, arb_q, arb_d;
  logic [31:0]      rdata_q, rdata_d, win_val;
  logic             err_q;
  logic             in_tbl;
  logic [SEL_W-1:0] tbl_off;
  redir_t           ent [N_ENT];
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[23:8], bus_wdata[31:28]};
  assign tbl_off = sel_q - R_TABLE;
  assign in_tbl  = (sel_q >= R_TABLE) && ({1'b0, sel_q} < TBL_END);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit;
    assign hit = win_wr & in_tbl & (tbl_off[SEL_W-1:1] == (SEL_W-1)'(g));
    irq_redir_entry ent_i (
      .clk(clk), .rst_n(rst_n_s),
      .wr_lo(hit & ~sel_q[0]), .wr_hi(hit & sel_q[0]),
      .wdata(bus_wdata), .ent(ent[g])
    );
    assign ent_vec[8*g +: 8]   = ent[g].vec;
    assign ent_dmode[3*g +: 3] = ent[g].dmode;
    assign ent_dstm[g]         = ent[g].dstm;
    assign ent_pol[g]          = ent[g].pol;
    assign ent_trig[g]         = ent[g].trig;
    assign ent_mask[g]         = ent[g].mask;
    assign ent_dest[8*g +: 8]  = ent[g].dest;
  end

  // value seen through the data window
  always_comb begin
    win_val = '0;
    if (sel_q == R_IDENT)      win_val = {4'h0, id_q, 24'h0};
    else if (sel_q == R_CAPS)  win_val = {8'h00, TOP_IDX, 8'h00, VERSION};
    else if (sel_q == R_ARBID) win_val = {4'h0, arb_q, 24'h0};
    else if (in_tbl) begin
      for (int k = 0; k < N_ENT; k++) begin
        if (tbl_off[SEL_W-1:1] == (SEL_W-1)'(k))
          win_val = sel_q[0] ? hi_image(ent[k]) : lo_image(ent[k]);
      end
    end
  end

  // next state
  always_comb begin
    sel_d   = sel_q;
    id_d    = id_q;
    arb_d   = arb_q;
    rdata_d = rdata_q;
    if (sel_wr) sel_d = bus_wdata[SEL_W-1:0];
    if (win_wr && sel_q == R_IDENT) id_d  = bus_wdata[27:24];
    if (win_wr && sel_q == R_ARBID) arb_d = bus_wdata[27:24];
    if (sel_rd)                rdata_d = {24'h0, sel_q};
    else if (win_rd)           rdata_d = win_val;
    else if (bad_acc & bus_rd) rdata_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_q   <= '0;
      id_q    <= ID_INIT;
      arb_q   <= ID_INIT;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= sel_d;
      if (win_wr) begin
        id_q  <= id_d;
        arb_q <= arb_d;
      end
      if (bus_rd) rdata_q <= rdata_d;
      err_q <= bad_acc;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int N_ENT  = 24,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_err,
  input logic [7:0]         sel_q,
  input logic [N_ENT-1:0]   ent_mask,
  input logic [8*N_ENT-1:0] ent_dest
);
  logic       acc, bad, sel_in_tbl;
  logic [7:0] dest_of_sel, off;

  assign acc = bus_wr | bus_rd;
  assign bad = acc && bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(16);
  assign off = sel_q - 8'h10;
  assign sel_in_tbl = (sel_q >= 8'h10) && ({1'b0, sel_q} < 9'(16 + 2*N_ENT));

  always_comb begin
    dest_of_sel = '0;
    for (int k = 0; k < N_ENT; k++)
      if (off[7:1] == 7'(k)) dest_of_sel = ent_dest[8*k +: 8];
  end

  AST_BAD_OFFSET_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    bad |=> bus_err); // R9
  AST_GOOD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bad |=> !bus_err); // R9
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bad && bus_rd) |=> bus_rdata == 32'h0); // R9
  AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> sel_q == $past(bus_wdata[7:0])); // R1
  AST_ENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bus_wr && bus_addr == ADDR_W'(16)) |=> ($stable(ent_mask) && $stable(ent_dest))); // R10
  AST_HI_DEST_MAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == ADDR_W'(16) && sel_in_tbl && sel_q[0])
      |=> dest_of_sel == $past(bus_wdata[31:24])); // R5
endmodule

bind irq_route_regs irq_route_regs_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .sel_q(sel_q), .ent_mask(ent_mask), .ent_dest(ent_dest)
);

// File: tb/irq_route_regs_tb_top.sv
`timescale 1ns/1ps
module irq_route_regs_tb_top;
  localparam int         N   = 24;
  localparam int         AW  = 8;
  localparam logic [3:0] IDI = 4'h3;
  localparam logic [7:0] VER = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_wr = 1'b0, b_rd = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [31:0]   b_wdata = '0;
  logic [31:0]   rdata;
  logic          err;
  logic [8*N-1:0] o_vec, o_dest;
  logic [3*N-1:0] o_dm;
  logic [N-1:0]   o_dstm, o_pol, o_trig, o_mask;

  always #2 clk = ~clk;

  irq_route_regs #(.N_ENT(N), .ADDR_W(AW), .ID_INIT(IDI), .VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .bus_err(err),
    .ent_vec(o_vec), .ent_dmode(o_dm), .ent_dstm(o_dstm), .ent_pol(o_pol),
    .ent_trig(o_trig), .ent_mask(o_mask), .ent_dest(o_dest)
  );

  // reference model
  logic [7:0]  m_sel;
  logic [3:0]  m_id, m_arb;
  logic [63:0] m_ent [N];
  logic [31:0] m_rdata;
  logic        m_err;
  int checks = 0, errors = 0;
  bit chk_en = 0, done = 0;
  string tag = "R7";

  function automatic logic [31:0] m_reg(logic [7:0] s);
    int i;
    if (s == 8'h00) return {4'h0, m_id, 24'h0};
    if (s == 8'h01) return {8'h00, 8'(N-1), 8'h00, VER};
    if (s == 8'h02) return {4'h0, m_arb, 24'h0};
    if (s >= 8'h10 && int'(s) < 16 + 2*N) begin
      i = (int'(s) - 16) / 2;
      return s[0] ? m_ent[i][63:32] : m_ent[i][31:0];
    end
    return 32'h0;
  endfunction

  task automatic m_reset();
    m_sel = 0; m_id = IDI; m_arb = IDI; m_rdata = 0; m_err = 0;
    for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic bad;
      bad = (b_wr | b_rd) && b_addr != 0 && b_addr != 16;
      if (b_rd) begin
        if (b_addr == 0)       m_rdata = {24'h0, m_sel};
        else if (b_addr == 16) m_rdata = m_reg(m_sel);
        else                   m_rdata = 0;
      end
      m_err = bad;
      if (b_wr && b_addr == 16) begin
        if (m_sel == 8'h00) m_id = b_wdata[27:24];
        else if (m_sel == 8'h02) m_arb = b_wdata[27:24];
        else if (m_sel >= 8'h10 && int'(m_sel) < 16 + 2*N) begin
          if (m_sel[0]) m_ent[(int'(m_sel)-16)/2][63:32] = b_wdata & 32'hFF00_0000;
          else          m_ent[(int'(m_sel)-16)/2][31:0]  = b_wdata & 32'h0001_AFFF;
        end
      end
      if (b_wr && b_addr == 0) m_sel = b_wdata[7:0];
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      logic [8*N-1:0] e_vec, e_dest;
      logic [3*N-1:0] e_dm;
      logic [N-1:0]   e_dstm, e_pol, e_trig, e_mask;
      for (int i = 0; i < N; i++) begin
        e_vec[8*i +: 8]  = m_ent[i][7:0];
        e_dm[3*i +: 3]   = m_ent[i][10:8];
        e_dstm[i]        = m_ent[i][11];
        e_pol[i]         = m_ent[i][13];
        e_trig[i]        = m_ent[i][15];
        e_mask[i]        = m_ent[i][16];
        e_dest[8*i +: 8] = m_ent[i][63:56];
      end
      chk(tag, "rdata", 64'(rdata), 64'(m_rdata));
      chk(tag, "err (R9)", 64'(err), 64'(m_err));
      chk(tag, "vec out (R10)", 64'(o_vec[63:0]), 64'(e_vec[63:0]));
      checks++;
      if (o_vec !== e_vec || o_dest !== e_dest || o_dm !== e_dm || o_dstm !== e_dstm ||
          o_pol !== e_pol || o_trig !== e_trig || o_mask !== e_mask) begin
        errors++;
        $display("FAIL %s R10 field outputs: actual mask %h dest %h expected mask %h dest %h",
                 tag, o_mask, o_dest, e_mask, e_dest);
      end
    end
  end

  task automatic acc(bit wr, bit rd, logic [AW-1:0] a, logic [31:0] d, string t);
    @(negedge clk);
    tag = t; b_wr = wr; b_rd = rd; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_wr = 0; b_rd = 0;
  endtask

  task automatic wreg(logic [7:0] s, logic [31:0] d, string t);
    acc(1, 0, 0, {24'h0, s}, t);
    acc(1, 0, 16, d, t);
  endtask

  task automatic rreg(logic [7:0] s, string t);
    acc(1, 0, 0, {24'h0, s}, t);
    acc(0, 1, 16, 32'h0, t);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1;
    repeat (3) @(negedge clk);
    // R7 reset values
    acc(0, 1, 0, 0, "R7");
    rreg(8'h00, "R7");
    rreg(8'h02, "R7");
    rreg(8'h10, "R7");
    rreg(8'h11 + 8'(2*(N-1)), "R7");
    // R1 select readback
    acc(1, 0, 0, 32'hFFFF_FF5A, "R1");
    acc(0, 1, 0, 0, "R1");
    // R2 identity, R4 arbitration identity
    wreg(8'h00, 32'hFFFF_FFFF, "R2");
    rreg(8'h00, "R2");
    wreg(8'h02, 32'h0A5A_5A5A, "R4");
    rreg(8'h02, "R4");
    rreg(8'h00, "R4");
    // R3 capability word read-only
    rreg(8'h01, "R3");
    wreg(8'h01, 32'hFFFF_FFFF, "R3");
    rreg(8'h01, "R3");
    // R6 reserved bits scrubbed
    wreg(8'h10, 32'hFFFF_FFFF, "R6");
    rreg(8'h10, "R6");
    wreg(8'h11, 32'hFFFF_FFFF, "R6");
    rreg(8'h11, "R6");
    wreg(8'h10 + 8'(2*(N-1)), 32'h0000_A35C, "R6");
    rreg(8'h10 + 8'(2*(N-1)), "R6");
    // R8 undefined select values
    wreg(8'h05, 32'hFFFF_FFFF, "R8");
    rreg(8'h05, "R8");
    wreg(8'h0F, 32'hFFFF_FFFF, "R8");
    wreg(8'(16 + 2*N), 32'hFFFF_FFFF, "R8");
    rreg(8'(16 + 2*N), "R8");
    wreg(8'hFF, 32'hFFFF_FFFF, "R8");
    rreg(8'hFF, "R8");
    rreg(8'h10 + 8'(2*(N-1)), "R8");
    rreg(8'h00, "R8");
    // R9 bad offsets
    acc(1, 0, 8'd16, 32'h0, "R9");
    acc(1, 0, 0, 32'h0000_0012, "R9");
    acc(1, 0, 8'd4, 32'h0000_0013, "R9");
    acc(1, 0, 8'd20, 32'hFFFF_FFFF, "R9");
    acc(0, 1, 8'd8, 0, "R9");
    acc(0, 1, 0, 0, "R9");
    acc(0, 1, 16, 0, "R9");
    // R5 full table sweep, R10 outputs follow
    for (int n = 0; n < N; n++) begin
      wreg(8'h10 + 8'(2*n), {15'h0, 1'b0, 8'(n * 37), 8'(n + 1)} ^ 32'h0000_1800, "R5");
      wreg(8'h11 + 8'(2*n), {8'(255 - n), 24'h0}, "R5");
    end
    for (int n = 0; n < N; n++) begin
      rreg(8'h10 + 8'(2*n), "R5");
      rreg(8'h11 + 8'(2*n), "R5");
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule